// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Break Control

This block serialises bytes onto an asynchronous line. A CPU-side write fills a one-entry holding register. A shift stage pulls the character from that register and sends it as a start bit, 5 to 8 data bits (least significant first), an optional parity bit and a stop period. All timing comes from a baud enable pulse `tick_i`, which is generated outside the block. One bit time is 1, 16 or 64 ticks, as set by the rate factor input.

The line can be held in the spacing state (a break) on request. A break only begins at a character boundary. When the break ends, the line stays at mark for at least one bit time before the next character starts. Turning the transmitter off never cuts a character short: the character in the shift stage is sent in full, and the line then rests at mark.

Two status outputs are provided:
- `tx_rdy_o` shows that the holding register can take a new byte.
- `tx_empty_o` latches the moment the shift stage runs dry with nothing waiting behind it.

Top module: `serial_tx_brk`

## Requirements
- R1: A frame is a start bit at 0, then `5 + char_len_i` data bits (char_len_i 0..3 gives 5..8 bits) taken least significant bit first, then the optional parity bit, then the stop period at 1. When nothing is being sent, `txd_o` is 1.
- R2: With `par_en_i`=1 a parity bit follows the data. With `par_even_i`=1 the number of ones in the data and parity bits together is even. With `par_even_i`=0 that number is odd.
- R3: One bit time lasts 1, 16 or 64 ticks for `factor_i` = 00, 01 or 1x. The stop period is selected by `stop_sel_i`:
  - 01 or 00: one bit time.
  - 10: one and a half bit times. At factor 00 this becomes two bit times.
  - 11: two bit times.
  
  Configuration is sampled at the tick where a character starts.
- R4: A character starts only at a tick where `tx_en_i`=1 and the holding register is full. If `tx_en_i` falls during a character, that character is still sent in full, and `txd_o` then stays 1.
- R5: A break request (`break_i`=1 with `tx_en_i`=1) takes effect only at a character boundary. It holds `txd_o` at 0 until a tick where `break_i` or `tx_en_i` is 0. A break takes priority over a waiting character.
- R6: When a break ends, `txd_o` stays at 1 for one full bit time. The bit time used is the one sampled when the break began. After that, the next character may start no earlier than the following tick.
- R7: `tx_rdy_o` = `tx_en_i` AND (holding register empty).
  - A write (`wr_i`) fills the holding register.
  - The start of a character empties it.
  - A write in the same cycle as a start leaves the register full with the new byte, while the old byte is the one sent.
- R8: `tx_empty_o` sets when a stop period ends while the holding register is empty. The register state used is the one before any write in that cycle. It is cleared by `stat_rd_i` or by a rising edge of `tx_en_i`. If a set and a clear fall in the same cycle, the set wins.
- R9: A character waiting at the end of a stop period starts at that same tick. There is no idle gap between frames, and `tx_empty_o` stays 0.
- R10: While `rst_ni`=0, `txd_o`=1, `tx_empty_o`=0 and the holding register is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Baud enable, one cycle per tick |
| factor_i | input | 2 | Ticks per bit: 00=1, 01=16, 1x=64 |
| char_len_i | input | 2 | Data bits minus 5 |
| par_en_i | input | 1 | Parity bit enable |
| par_even_i | input | 1 | 1 = even parity, 0 = odd |
| stop_sel_i | input | 2 | Stop period: 01/00 = 1, 10 = 1.5, 11 = 2 bit times |
| tx_en_i | input | 1 | Transmitter enable |
| break_i | input | 1 | Break request |
| wr_i | input | 1 | Load holding register |
| wr_data_i | input | 8 | Byte to load |
| stat_rd_i | input | 1 | Status read strobe, clears `tx_empty_o` |
| txd_o | output | 1 | Serial line |
| tx_rdy_o | output | 1 | Holding register can accept a byte |
| tx_empty_o | output | 1 | Shift stage finished with nothing pending |

## Verification
Two pairs of events can fall in the same cycle and must be resolved:
- A stop period can end in the same cycle as a status read (or as the rising edge of the enable). The empty flag must then read 1 afterwards.
- A write can arrive at the very tick a character leaves the holding register. The holding register must then stay full with the new byte, while the old byte goes out.

Both cases are provoked in a long phase with random ticks, writes, reads, breaks and configuration changes. A behavioural reference model, built on a queue of line segments, is compared with the outputs on every clock. The bench counts the cycles in which each collision actually happened and requires that each count is non-zero.

// File: rtl/stx_pkg.sv
package stx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_DATA  = 3'd2,
    ST_PAR   = 3'd3,
    ST_STOP  = 3'd4,
    ST_BRK   = 3'd5,
    ST_MARK  = 3'd6
  } stx_state_e;
endpackage

// File: rtl/stx_hold.sv
module stx_hold #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              take_i,
  output logic              full_o,
  output logic [DATA_W-1:0] data_o
);
  logic              full_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else begin
      if (wr_i) begin
        full_q <= 1'b1;
        data_q <= wr_data_i;
      end else if (take_i) begin
        full_q <= 1'b0;
      end
    end
  end

  assign full_o = full_q;
  assign data_o = data_q;

  assert_take_full_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |-> full_q);
  assert_wr_fills_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> full_q);
endmodule

// File: rtl/stx_timer.sv
module stx_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             run_i,
  input  logic             restart_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  assign done_o = run_i && tick_i && (cnt_q == len_i - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (restart_i)         cnt_q <= '0;
    else if (run_i && tick_i)   cnt_q <= cnt_q + 1'b1;
  end

  assert_cnt_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (cnt_q < len_i));
endmodule

// File: rtl/stx_engine.sv
module stx_engine import stx_pkg::*; #(
  parameter  int unsigned DATA_W  = 8,
  parameter  int unsigned FAC_MID = 16,
  parameter  int unsigned FAC_HI  = 64,
  localparam int unsigned CNT_W   = $clog2(2 * FAC_HI + 1),
  localparam int unsigned IDX_W   = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              en_i,
  input  logic              brk_i,
  input  logic [1:0]        factor_i,
  input  logic [1:0]        len_sel_i,
  input  logic [1:0]        stop_sel_i,
  input  logic              par_en_i,
  input  logic              par_even_i,
  input  logic              hr_full_i,
  input  logic [DATA_W-1:0] hr_data_i,
  output logic              take_o,
  output logic              char_done_o,
  output logic              txd_o
);
  stx_state_e       state_q, state_d;
  logic [CNT_W-1:0] bit_q, stop_q, bit_new, stop_new, tmr_len;
  logic [IDX_W-1:0] nbits_q, idx_q;
  logic [DATA_W-1:0] sh_q, mask;
  logic             par_on_q, par_q, par_calc;
  logic             done, boundary, go_brk, go_chr, run, restart;

  function automatic logic [CNT_W-1:0] ticks_for(input logic [1:0] f);
    logic [CNT_W-1:0] t;
    case (f)
      2'b00:   t = CNT_W'(1);
      2'b01:   t = CNT_W'(FAC_MID);
      default: t = CNT_W'(FAC_HI);
    endcase
    return t;
  endfunction

  always_comb begin
    bit_new = ticks_for(factor_i);
    case (stop_sel_i)
      2'b10:   stop_new = (factor_i == 2'b00) ? (bit_new << 1) : (bit_new + (bit_new >> 1));
      2'b11:   stop_new = bit_new << 1;
      default: stop_new = bit_new;
    endcase
  end

  always_comb begin
    for (int i = 0; i < DATA_W; i++) mask[i] = (i < 5 + int'(len_sel_i));
    par_calc = ^(hr_data_i & mask);
    if (!par_even_i) par_calc = ~par_calc;
  end

  assign tmr_len  = (state_q == ST_STOP) ? stop_q : bit_q;
  assign run      = (state_q != ST_IDLE) && (state_q != ST_BRK);
  assign restart  = !run || done;

  stx_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .run_i     (run),
    .restart_i (restart),
    .len_i     (tmr_len),
    .done_o    (done)
  );

  assign char_done_o = (state_q == ST_STOP) && done;
  assign boundary    = ((state_q == ST_IDLE) && tick_i) || char_done_o;
  assign go_brk      = boundary && en_i && brk_i;
  assign go_chr      = boundary && !go_brk && en_i && hr_full_i;
  assign take_o      = go_chr;

  always_comb begin
    state_d = state_q;
    if (boundary) begin
      if (go_brk)      state_d = ST_BRK;
      else if (go_chr) state_d = ST_START;
      else             state_d = ST_IDLE;
    end else begin
      case (state_q)
        ST_START: if (done) state_d = ST_DATA;
        ST_DATA:  if (done && idx_q == nbits_q) state_d = par_on_q ? ST_PAR : ST_STOP;
        ST_PAR:   if (done) state_d = ST_STOP;
        ST_BRK:   if (tick_i && (!brk_i || !en_i)) state_d = ST_MARK;
        ST_MARK:  if (done) state_d = ST_IDLE;
        default:  state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      bit_q    <= CNT_W'(1);
      stop_q   <= CNT_W'(1);
      nbits_q  <= '0;
      idx_q    <= '0;
      sh_q     <= '0;
      par_on_q <= 1'b0;
      par_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      if (go_chr) begin
        bit_q    <= bit_new;
        stop_q   <= stop_new;
        nbits_q  <= IDX_W'(4 + int'(len_sel_i));
        idx_q    <= '0;
        sh_q     <= hr_data_i;
        par_on_q <= par_en_i;
        par_q    <= par_calc;
      end else if (go_brk) begin
        bit_q    <= bit_new;
      end else if (state_q == ST_DATA && done) begin
        sh_q  <= sh_q >> 1;
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  always_comb begin
    case (state_q)
      ST_START: txd_o = 1'b0;
      ST_DATA:  txd_o = sh_q[0];
      ST_PAR:   txd_o = par_q;
      ST_BRK:   txd_o = 1'b0;
      default:  txd_o = 1'b1;
    endcase
  end

  assert_brk_at_boundary_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_BRK && $past(state_q) != ST_BRK) |->
      ($past(state_q) == ST_IDLE || $past(state_q) == ST_STOP));
  assert_mark_after_brk_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(state_q) == ST_BRK && state_q != ST_BRK) |-> state_q == ST_MARK);
  assert_start_enabled_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_START && $past(state_q) != ST_START) |-> $past(en_i && hr_full_i));
endmodule

// File: rtl/serial_tx_brk.sv
module serial_tx_brk #(
  parameter  int unsigned DATA_W  = 8,
  parameter  int unsigned FAC_MID = 16,
  parameter  int unsigned FAC_HI  = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [1:0]        factor_i,
  input  logic [1:0]        char_len_i,
  input  logic              par_en_i,
  input  logic              par_even_i,
  input  logic [1:0]        stop_sel_i,
  input  logic              tx_en_i,
  input  logic              break_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              stat_rd_i,
  output logic              txd_o,
  output logic              tx_rdy_o,
  output logic              tx_empty_o
);
  logic              hr_full, take, char_done, en_q, emt_q, emt_set;
  logic [DATA_W-1:0] hr_data;

  stx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (wr_i),
    .wr_data_i (wr_data_i),
    .take_i    (take),
    .full_o    (hr_full),
    .data_o    (hr_data)
  );

  stx_engine #(.DATA_W(DATA_W), .FAC_MID(FAC_MID), .FAC_HI(FAC_HI)) u_engine (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick_i),
    .en_i        (tx_en_i),
    .brk_i       (break_i),
    .factor_i    (factor_i),
    .len_sel_i   (char_len_i),
    .stop_sel_i  (stop_sel_i),
    .par_en_i    (par_en_i),
    .par_even_i  (par_even_i),
    .hr_full_i   (hr_full),
    .hr_data_i   (hr_data),
    .take_o      (take),
    .char_done_o (char_done),
    .txd_o       (txd_o)
  );

  assign emt_set = char_done && !hr_full;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      emt_q <= 1'b0;
    end else begin
      en_q <= tx_en_i;
      if (emt_set)                             emt_q <= 1'b1;
      else if (stat_rd_i || (tx_en_i && !en_q)) emt_q <= 1'b0;
    end
  end

  assign tx_rdy_o   = tx_en_i && !hr_full;
  assign tx_empty_o = emt_q;

  assert_emt_rise_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(emt_q) |-> $past(char_done && !hr_full));
  assert_emt_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (emt_q && stat_rd_i && !emt_set) |=> !emt_q);
endmodule

// File: tb/sim_serial_tx_brk.sv
`timescale 1ns/1ps
module sim_serial_tx_brk;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic tick_i = 1'b0;
  logic [1:0] factor_i = 2'b00, char_len_i = 2'b11, stop_sel_i = 2'b01;
  logic par_en_i = 1'b0, par_even_i = 1'b0;
  logic tx_en_i = 1'b0, break_i = 1'b0, wr_i = 1'b0, stat_rd_i = 1'b0;
  logic [7:0] wr_data_i = 8'h00;
  logic txd_o, tx_rdy_o, tx_empty_o;

  always #4 clk = ~clk;

  serial_tx_brk u0 (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i), .factor_i(factor_i),
    .char_len_i(char_len_i), .par_en_i(par_en_i), .par_even_i(par_even_i),
    .stop_sel_i(stop_sel_i), .tx_en_i(tx_en_i), .break_i(break_i), .wr_i(wr_i),
    .wr_data_i(wr_data_i), .stat_rd_i(stat_rd_i), .txd_o(txd_o),
    .tx_rdy_o(tx_rdy_o), .tx_empty_o(tx_empty_o)
  );

  int checks = 0, fails = 0;
  int tick_div = 1, tick_cnt = 0;
  bit tick_rand = 0;

  // reference model: queue of line segments
  int    seg_lvl[$];
  int    seg_len[$];
  string seg_tag[$];
  int    m_mode = 0;  // 0 idle, 1 frame, 2 break, 3 mark
  int    m_rem = 0, m_brk_n = 1;
  bit    m_full = 0, m_emt = 0, m_en_q = 0;
  logic [7:0] m_hold = 8'h00;
  int    co_rd_set = 0, co_wr_take = 0;

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: %s actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int ticks_of(input logic [1:0] f);
    return (f == 2'b00) ? 1 : (f == 2'b01) ? 16 : 64;
  endfunction

  task automatic build(input logic [7:0] d);
    int n, len, ones, s;
    n = ticks_of(factor_i);
    len = 5 + int'(char_len_i);
    ones = 0;
    seg_lvl.push_back(0); seg_len.push_back(n); seg_tag.push_back("R1 start");
    for (int i = 0; i < len; i++) begin
      seg_lvl.push_back(int'(d[i])); seg_len.push_back(n); seg_tag.push_back("R1 data");
      ones += int'(d[i]);
    end
    if (par_en_i) begin
      seg_lvl.push_back(par_even_i ? (ones % 2) : 1 - (ones % 2));
      seg_len.push_back(n); seg_tag.push_back("R2 parity");
    end
    case (stop_sel_i)
      2'b10:   s = (n == 1) ? 2 : n + n / 2;
      2'b11:   s = 2 * n;
      default: s = n;
    endcase
    seg_lvl.push_back(1); seg_len.push_back(s); seg_tag.push_back("R3 stop");
  endtask

  always @(posedge clk) begin
    if (!rst_ni) begin
      seg_lvl.delete(); seg_len.delete(); seg_tag.delete();
      m_mode = 0; m_rem = 0; m_full = 0; m_emt = 0; m_en_q = 0;
    end else begin
      bit boundary, cend, take, set;
      boundary = 0; cend = 0; take = 0;
      if (tick_i) begin
        case (m_mode)
          1: begin
            m_rem--;
            if (m_rem == 0) begin
              void'(seg_lvl.pop_front()); void'(seg_len.pop_front()); void'(seg_tag.pop_front());
              if (seg_len.size() == 0) begin cend = 1; boundary = 1; end
              else m_rem = seg_len[0];
            end
          end
          2: if (!break_i || !tx_en_i) begin m_mode = 3; m_rem = m_brk_n; end
          3: begin m_rem--; if (m_rem == 0) m_mode = 0; end
          default: boundary = 1;
        endcase
      end
      if (boundary) begin
        if (tx_en_i && break_i) begin m_mode = 2; m_brk_n = ticks_of(factor_i); end
        else if (tx_en_i && m_full) begin build(m_hold); m_mode = 1; m_rem = seg_len[0]; take = 1; end
        else m_mode = 0;
      end
      set = cend && !m_full;
      if (take && wr_i) co_wr_take++;
      if (set && (stat_rd_i || (tx_en_i && !m_en_q))) co_rd_set++;
      if (set) m_emt = 1;
      else if (stat_rd_i || (tx_en_i && !m_en_q)) m_emt = 0;
      if (wr_i) begin m_hold = wr_data_i; m_full = 1; end
      else if (take) m_full = 0;
      m_en_q = tx_en_i;
    end
  end

  always @(negedge clk) begin
    if (rst_ni) begin
      int exp_txd;
      string tag;
      case (m_mode)
        1: begin exp_txd = seg_lvl[0]; tag = seg_tag[0]; end
        2: begin exp_txd = 0; tag = "R5 break"; end
        3: begin exp_txd = 1; tag = "R6 mark"; end
        default: begin exp_txd = 1; tag = "R4 idle"; end
      endcase
      chk(txd_o === exp_txd[0], tag, "txd_o", int'(txd_o), exp_txd);
      chk(tx_rdy_o === (tx_en_i && !m_full), "R7", "tx_rdy_o", int'(tx_rdy_o), int'(tx_en_i && !m_full));
      chk(tx_empty_o === m_emt, "R8", "tx_empty_o", int'(tx_empty_o), int'(m_emt));
    end
  end

  always @(posedge clk) begin
    #2;
    tick_cnt++;
    if (tick_rand) tick_i = ($urandom % 3 == 0);
    else           tick_i = (tick_cnt % tick_div) == 0;
  end

  task automatic step(input int n = 1);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic send(input logic [7:0] d);
    wr_i = 1'b1; wr_data_i = d; step(); wr_i = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, actual 1 expected 0");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    bit ok;
    void'($urandom(7));
    step(3);
    @(negedge clk);
    chk(txd_o === 1'b1 && tx_empty_o === 1'b0 && tx_rdy_o === 1'b0, "R10", "reset outputs",
        {txd_o, tx_empty_o, tx_rdy_o}, 3'b100);
    step();
    rst_ni = 1'b1;
    step(2);

    // R1: 8 bits, 1X, one stop
    tx_en_i = 1'b1; tick_div = 1;
    send(8'hA5); step(20);
    @(negedge clk);
    chk(tx_empty_o === 1'b1, "R8", "empty after frame", int'(tx_empty_o), 1);
    step(); stat_rd_i = 1'b1; step(); stat_rd_i = 1'b0;
    @(negedge clk);
    chk(tx_empty_o === 1'b0, "R8", "empty after read", int'(tx_empty_o), 0);
    step();

    // R2: 5 bits even parity at 16X, tick every 2 clocks
    char_len_i = 2'b00; par_en_i = 1'b1; par_even_i = 1'b1; factor_i = 2'b01; tick_div = 2;
    send(8'h13); step(450);
    par_even_i = 1'b0; send(8'h13); step(450);

    // R3: 7 bits odd parity 1.5 stop at 16X, then 6 bits 1.5 stop at 1X, 2 stop at 64X
    char_len_i = 2'b10; stop_sel_i = 2'b10;
    send(8'h5C); step(450);
    factor_i = 2'b00; char_len_i = 2'b01; tick_div = 1;
    send(8'h2B); step(20);
    factor_i = 2'b10; stop_sel_i = 2'b11; par_en_i = 1'b0; char_len_i = 2'b11;
    send(8'hC3); step(800);

    // R9: back-to-back at 1X
    factor_i = 2'b00; stop_sel_i = 2'b01;
    stat_rd_i = 1'b1; step(); stat_rd_i = 1'b0;
    send(8'h0F);
    while (!tx_rdy_o) step();
    send(8'hF0);
    ok = 1;
    for (int i = 0; i < 15; i++) begin @(negedge clk); if (tx_empty_o) ok = 0; step(); end
    chk(ok, "R9", "empty stayed low between frames", int'(!ok), 0);
    step(20);

    // R4: disable mid frame, write while disabled, re-enable
    send(8'h81); step(4); tx_en_i = 1'b0; step(30);
    @(negedge clk);
    chk(txd_o === 1'b1 && tx_empty_o === 1'b1, "R4", "frame finished after disable",
        {txd_o, tx_empty_o}, 2'b11);
    step(); send(8'h7E); step(30);
    @(negedge clk);
    chk(tx_rdy_o === 1'b0 && txd_o === 1'b1, "R4", "disabled holds line", {tx_rdy_o, txd_o}, 2'b01);
    step(); tx_en_i = 1'b1; step(30);

    // R5/R6: break raised mid frame at 16X, byte waiting when released
    factor_i = 2'b01; tick_div = 1;
    send(8'h55); step(40); break_i = 1'b1; step(200);
    @(negedge clk);
    chk(txd_o === 1'b0, "R5", "break holds line low", int'(txd_o), 0);
    step(); send(8'hAA); step(30); break_i = 1'b0; step(300);

    // random collision phase
    tick_rand = 1;
    for (int c = 0; c < 60000; c++) begin
      wr_i = ($urandom % 30 == 0);
      wr_data_i = 8'($urandom);
      stat_rd_i = ($urandom % 4 == 0);
      if (break_i ? ($urandom % 200 == 0) : ($urandom % 3000 == 0)) break_i = !break_i;
      if ($urandom % 4000 == 0) tx_en_i = !tx_en_i;
      if (!tx_en_i && $urandom % 100 == 0) tx_en_i = 1'b1;
      if ($urandom % 400 == 0) begin
        factor_i = ($urandom % 10 == 0) ? 2'b10 : 2'($urandom % 2);
        char_len_i = 2'($urandom); stop_sel_i = 2'($urandom);
        par_en_i = 1'($urandom); par_even_i = 1'($urandom);
      end
      step();
    end
    wr_i = 1'b0; stat_rd_i = 1'b0; break_i = 1'b0;
    step(2);
    chk(co_rd_set > 0, "R8", "set/read collisions seen", co_rd_set, 1);
    chk(co_wr_take > 0, "R7", "write/transfer collisions seen", co_wr_take, 1);
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule